// File: doc/BRIEF.md
# Translation Lookaside Buffer with Context Flush

This block keeps a small, fully associative set of recent virtual-page to physical-frame translations for a 32-bit, two-level paging scheme with 4 KB pages. The top 20 address bits form the page number used as the tag, and the low 12 bits pass through unchanged. A translation that is already held is returned in the same cycle. The page walk is then skipped.

After an external walker resolves a miss, it installs the translation through the fill port. A fill whose page number is already present overwrites that entry. Any other fill goes to the slot chosen by a round-robin pointer. A write to the page-directory base register, signalled on `ctxWrite`, drops every entry at once.

Lookups also apply a fixed user/kernel split. In user mode, an address at or above 0xC0000000 faults. A user-mode lookup that hits an entry marked kernel-only also faults. A fault never reports a hit.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid: every lookup reports `lkHit`=0.
- R2: A lookup whose page number matches a valid entry, and that is not blocked, reports `lkHit`=1 in the same cycle. `lkPaddr` is then {stored frame number, lkVaddr[11:0]}.
- R3: A cycle with `ctxWrite`=1 invalidates all entries. From the next cycle every lookup misses.
- R4: A user-mode lookup (`lkUser`=1) with lkVaddr >= 0xC0000000 reports `lkFault`=1 and `lkHit`=0, whether or not the page is held. The same lookup in kernel mode (`lkUser`=0) hits normally, and the page at 0xBFFFF000 is not blocked.
- R5: Each entry stores the `fillUser` bit (1 = user accessible). A user-mode lookup that matches an entry with this bit 0 reports `lkFault`=1 and `lkHit`=0.
- R6: A fill whose page number matches a valid entry overwrites that entry's frame and user bit in place. No second copy is created.
- R7: Fills that match no entry are written to slots 0, 1, …, 7 in turn and then wrap to slot 0. The oldest such fill is evicted first. A matching fill does not advance the pointer.
- R8: If `ctxWrite` and `fillValid` are both 1 in one cycle, the flush wins and the table is left empty. The replacement pointer also returns to slot 0.
- R9: A miss that is not blocked reports `lkHit`=0, `lkFault`=0 and `lkPaddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 32 | Virtual address to translate |
| lkUser | input | 1 | 1 = lookup made in user mode |
| lkHit | output | 1 | Translation found and allowed |
| lkFault | output | 1 | User-mode access blocked |
| lkPaddr | output | 32 | Physical address when hit, else 0 |
| fillValid | input | 1 | Install a translation |
| fillVaddr | input | 32 | Virtual address of the page to install (low 12 bits ignored) |
| fillPfn | input | 20 | Physical frame number |
| fillUser | input | 1 | 1 = page accessible in user mode |
| ctxWrite | input | 1 | Page-directory base write: flush all entries |

## Verification
The bench builds the block with its default parameters: 8 entries, a 12-bit page offset and the kernel boundary at 0xC0000000. With only eight slots, nine or ten fills are enough to fill the whole table, wrap the round-robin pointer and show which entry is evicted. The boundary can be probed on both sides, at page 0xBFFFF and page 0xC0000. An in-place overwrite placed between allocations shows whether a matching fill wrongly moved the pointer.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Strobes from the control module to the entry array.
  typedef struct packed {
    logic flushAll;  // invalidate every entry this cycle
    logic writeEn;   // write the fill into the indexed slot
  } xlatStrobe_t;
endpackage

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int VPN_W    = 20,
  parameter int PFN_W    = 20,
  parameter int KERN_VPN = 'hC0000,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlatStrobe_t       strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic              fillUser,
  output logic              fillMatchAny,
  output logic [IDX_W-1:0]  fillMatchIdx,
  input  logic              lkValid,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic              lkUser,
  output logic              lkHit,
  output logic              lkFault,
  output logic [PFN_W-1:0]  lkPfn
);
  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entUser;
  logic [VPN_W-1:0]   entVpn [ENTRIES];
  logic [PFN_W-1:0]   entPfn [ENTRIES];

  logic [ENTRIES-1:0] lkMatchVec;
  logic [ENTRIES-1:0] fillMatchVec;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign lkMatchVec[g]   = entValid[g] && (entVpn[g] == lkVpn);
      assign fillMatchVec[g] = entValid[g] && (entVpn[g] == fillVpn);
    end
  endgenerate

  logic              anyMatch;
  logic              matchUser;
  logic [PFN_W-1:0]  matchPfn;
  always_comb begin
    anyMatch  = 1'b0;
    matchUser = 1'b0;
    matchPfn  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkMatchVec[i]) begin
        anyMatch  = 1'b1;
        matchUser = matchUser | entUser[i];
        matchPfn  = matchPfn | entPfn[i];
      end
    end
  end

  always_comb begin
    fillMatchAny = 1'b0;
    fillMatchIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fillMatchVec[i]) begin
        fillMatchAny = 1'b1;
        fillMatchIdx = IDX_W'(i);
      end
    end
  end

  logic kernZone;
  logic userBlock;
  assign kernZone  = lkVpn >= VPN_W'(KERN_VPN);
  assign userBlock = lkUser && (kernZone || (anyMatch && !matchUser));
  assign lkHit     = lkValid && anyMatch && !userBlock;
  assign lkFault   = lkValid && userBlock;
  assign lkPfn     = lkHit ? matchPfn : '0;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flushAll) begin
      entValid <= '0;
    end else if (strobe.writeEn) begin
      entValid[wrIdx] <= 1'b1;
      entUser[wrIdx]  <= fillUser;
      entVpn[wrIdx]   <= fillVpn;
      entPfn[wrIdx]   <= fillPfn;
    end
  end

  // R6: in-place overwrite keeps tags unique
  p_unique_tags_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatchVec) && $onehot0(fillMatchVec));

  // R3: a flush leaves nothing to hit on the next cycle
  p_flush_empties_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> !anyMatch);
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fillValid,
  input  logic             ctxWrite,
  input  logic             fillMatchAny,
  input  logic [IDX_W-1:0] fillMatchIdx,
  output xlatStrobe_t      strobe,
  output logic [IDX_W-1:0] wrIdx
);
  logic [IDX_W-1:0] rrPtr;
  logic             allocate;

  assign strobe.flushAll = ctxWrite;
  assign strobe.writeEn  = fillValid && !ctxWrite;
  assign allocate        = strobe.writeEn && !fillMatchAny;
  assign wrIdx           = fillMatchAny ? fillMatchIdx : rrPtr;

  always_ff @(posedge clk) begin
    if (!rstN || ctxWrite) begin
      rrPtr <= '0;
    end else if (allocate) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  // R7: an in-place overwrite leaves the pointer where it was
  p_ptr_hold_on_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && fillMatchAny && !ctxWrite) |=> $stable(rrPtr));

  // R8: a flush, with or without a fill, returns the pointer to slot 0
  p_ptr_home_on_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctxWrite |=> (rrPtr == '0));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W             = 32,
  parameter int PA_W             = 32,
  parameter int OFF_W            = 12,
  parameter int ENTRIES          = 8,
  parameter logic [31:0] KERN_BASE = 32'hC000_0000,
  localparam int VPN_W           = VA_W - OFF_W,
  localparam int PFN_W           = PA_W - OFF_W,
  localparam int KERN_VPN        = int'(KERN_BASE >> OFF_W),
  localparam int IDX_W           = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [VA_W-1:0]  lkVaddr,
  input  logic             lkUser,
  output logic             lkHit,
  output logic             lkFault,
  output logic [PA_W-1:0]  lkPaddr,
  input  logic             fillValid,
  input  logic [VA_W-1:0]  fillVaddr,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillUser,
  input  logic             ctxWrite
);
  xlatStrobe_t      strobe;
  logic [IDX_W-1:0] wrIdx;
  logic             fillMatchAny;
  logic [IDX_W-1:0] fillMatchIdx;
  logic [PFN_W-1:0] lkPfn;

  xlat_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk, .rstN, .fillValid, .ctxWrite, .fillMatchAny, .fillMatchIdx,
    .strobe, .wrIdx
  );

  xlat_dpath #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .KERN_VPN(KERN_VPN)
  ) u_dpath (
    .clk, .rstN, .strobe, .wrIdx,
    .fillVpn(fillVaddr[VA_W-1:OFF_W]), .fillPfn, .fillUser,
    .fillMatchAny, .fillMatchIdx,
    .lkValid, .lkVpn(lkVaddr[VA_W-1:OFF_W]), .lkUser,
    .lkHit, .lkFault, .lkPfn
  );

  assign lkPaddr = lkHit ? {lkPfn, lkVaddr[OFF_W-1:0]} : '0;

  // R4/R5: a blocked access never reports a hit
  p_no_hit_on_fault_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(lkHit && lkFault));

  // R3: lookups in the cycle after a context write miss
  p_ctx_write_miss_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctxWrite |=> !lkHit);
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic        lkUser = 1'b0;
  logic        lkHit, lkFault;
  logic [31:0] lkPaddr;
  logic        fillValid = 1'b0;
  logic [31:0] fillVaddr = '0;
  logic [19:0] fillPfn = '0;
  logic        fillUser = 1'b0;
  logic        ctxWrite = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  xlat_cache u_xlat_cache (
    .clk, .rstN, .lkValid, .lkVaddr, .lkUser, .lkHit, .lkFault, .lkPaddr,
    .fillValid, .fillVaddr, .fillPfn, .fillUser, .ctxWrite
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive a lookup between edges, sample after settling
  task automatic lookup(input logic [31:0] va, input logic user);
    @(negedge clk);
    lkValid = 1'b1; lkVaddr = va; lkUser = user;
    #2;
  endtask

  task automatic expectHit(input string req, input logic [31:0] va, input logic user,
                           input logic [19:0] pfn);
    lookup(va, user);
    check(req, {31'd0, lkHit}, 32'd1);
    check(req, {31'd0, lkFault}, 32'd0);
    check(req, lkPaddr, {pfn, va[11:0]});
  endtask

  task automatic expectMiss(input string req, input logic [31:0] va, input logic user);
    lookup(va, user);
    check(req, {31'd0, lkHit}, 32'd0);
    check(req, {31'd0, lkFault}, 32'd0);
    check(req, lkPaddr, 32'd0);
  endtask

  task automatic expectFault(input string req, input logic [31:0] va);
    lookup(va, 1'b1);
    check(req, {31'd0, lkHit}, 32'd0);
    check(req, {31'd0, lkFault}, 32'd1);
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] pfn, input logic user,
                      input logic flush);
    @(negedge clk);
    lkValid = 1'b0;
    fillValid = 1'b1; fillVaddr = va; fillPfn = pfn; fillUser = user; ctxWrite = flush;
    @(negedge clk);
    fillValid = 1'b0; ctxWrite = 1'b0;
  endtask

  task automatic flushAll();
    @(negedge clk);
    ctxWrite = 1'b1;
    @(negedge clk);
    ctxWrite = 1'b0;
  endtask

  function automatic logic [31:0] pg(input int k);
    return 32'h0040_0000 + (k << 12);
  endfunction

  task automatic tReset();
    expectMiss("R1", 32'h0000_1234, 1'b0);
    expectMiss("R1", 32'hC000_0000, 1'b0);
  endtask

  task automatic tBasic();
    fill(32'h0001_2000, 20'hABCDE, 1'b1, 1'b0);
    expectHit("R2", 32'h0001_2345, 1'b0, 20'hABCDE);
    expectHit("R2", 32'h0001_2FFF, 1'b1, 20'hABCDE);
    expectMiss("R9", 32'h0001_3000, 1'b0);
    expectMiss("R9", 32'h0001_1FFF, 1'b1);
  endtask

  task automatic tSplit();
    fill(32'hC000_0000, 20'h00111, 1'b1, 1'b0);
    fill(32'hBFFF_F000, 20'h00222, 1'b1, 1'b0);
    expectHit("R4", 32'hC000_0010, 1'b0, 20'h00111);
    expectFault("R4", 32'hC000_0010);
    expectFault("R4", 32'hF000_0000);
    expectHit("R4", 32'hBFFF_FFFC, 1'b1, 20'h00222);
    fill(32'h0007_0000, 20'h00333, 1'b0, 1'b0);
    expectFault("R5", 32'h0007_0004);
    expectHit("R5", 32'h0007_0004, 1'b0, 20'h00333);
  endtask

  task automatic tFlush();
    flushAll();
    expectMiss("R3", 32'h0001_2345, 1'b0);
    expectMiss("R3", 32'hC000_0010, 1'b0);
    expectMiss("R3", 32'h0007_0004, 1'b0);
  endtask

  task automatic tReplace();
    flushAll();
    for (int k = 0; k < 8; k++) fill(pg(k), 20'h01000 + 20'(k), 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) expectHit("R7", pg(k), 1'b1, 20'h01000 + 20'(k));
    fill(pg(8), 20'h01008, 1'b1, 1'b0);          // pointer wraps: evicts slot 0
    expectMiss("R7", pg(0), 1'b1);
    expectHit("R7", pg(8), 1'b1, 20'h01008);
    fill(pg(1), 20'h02001, 1'b1, 1'b0);          // in place, pointer stays at 1
    expectHit("R6", pg(1), 1'b1, 20'h02001);
    expectHit("R6", pg(2), 1'b1, 20'h01002);
    fill(pg(9), 20'h01009, 1'b1, 1'b0);          // takes slot 1
    expectMiss("R7", pg(1), 1'b1);
    expectHit("R7", pg(2), 1'b1, 20'h01002);
    expectHit("R7", pg(9), 1'b1, 20'h01009);
  endtask

  task automatic tFlushFill();
    fill(pg(20), 20'h03000, 1'b1, 1'b1);         // flush and fill together
    expectMiss("R8", pg(20), 1'b1);
    expectMiss("R8", pg(9), 1'b1);
    // pointer back at slot 0: eight fresh fills, ninth evicts the first
    for (int k = 30; k < 39; k++) fill(pg(k), 20'h04000 + 20'(k), 1'b1, 1'b0);
    expectMiss("R8", pg(30), 1'b1);
    expectHit("R8", pg(31), 1'b1, 20'h04000 + 20'd31);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBasic();
    tSplit();
    tFlush();
    tReplace();
    tFlushFill();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule